// File: doc/BRIEF.md
# Ethernet Receive Frame Classifier

This block looks at the destination address of every received Ethernet frame and decides, once per frame, whether the frame is accepted and which classifier claimed it. The first six payload bytes of a frame (the destination address, first byte first) are collected from a byte stream. A 32-bit match vector is built from them: unicast, multicast and broadcast flags, per-frame side flags given with the first byte, an exact match against the port's own MAC address, and the hit bits of eight masked address filter slots.

Sixteen classifiers each reduce the match vector through an AND-enable mask and an OR-enable mask under one of four combine modes. The lowest-numbered classifier that hits and whose gate has its raw bit set wins. The decision, the class index and the match vector appear together in a single-cycle valid pulse. Configuration goes through a plain word-wide write port with a combinational read port.

The byte input follows valid/ready rules, but the block never applies back-pressure. `in_ready` is always high, so every cycle with `in_valid` high is a transfer. The decision output carries no handshake: the consumer must take it in the cycle it is valid.

Top module: `eth_rx_classifier`

## Requirements
- R1: After reset `out_valid`, `out_accept`, `out_class` and `out_match` are 0. Every configuration word reads 0, except the length word (address 2), which reads 0x0006_0000.
- R2: Configuration word addresses are as follows:
  - 0: own MAC bytes 0..3, byte 0 in [7:0].
  - 1: own MAC bytes 4..5 in [15:0].
  - 2: compare length in [19:16].
  - 3: slot types, slot n in [2n+1:2n].
  - 4: combine modes, classifier n in [2n+1:2n].
  - 8+4n+k for slot n: k=0 is compare low, 1 is compare high, 2 is mask low, 3 is mask high.
  - 40+2n for the AND mask of classifier n, and 41+2n for its OR mask.
  - 72+n for the gate of classifier n: allow in bit 6, raw in bit 5, phase in bit 4.
  
  Only the listed bits are stored and read back: high words keep [15:0], the length word keeps [19:16], the slot-type word keeps [15:0] and gates keep [6:4]. A write to any other address has no effect.
- R3: Frame timing works as follows:
  - A beat with `in_sof` starts a frame and its byte is DA byte 0.
  - When the sixth DA byte is accepted at clock edge E, `out_valid` is high for exactly the cycle after edge E+1.
  - A frame that ends (`in_eof`) before six bytes produces no pulse.
  - Bytes after the sixth, and beats with no frame open, are ignored.
  - `in_ready` is always 1.
- R4: Match vector fields are as follows:
  - bit 31: unicast (DA byte 0 bit 0 clear).
  - bit 30: multicast (that bit set).
  - bit 29: broadcast (all 48 bits ones).
  - bits 28, 27, 26, 24: `in_meta[3]`, `in_meta[2]`, `in_meta[1]` and `in_meta[0]`, sampled on the start beat.
  - bits [15:0]: always 0.
- R5: Bit 25 of the match vector is set when all six DA bytes equal the own MAC words, byte order as in R2.
- R6: Slot n drives match bit 16+n. Its type selects 0 = off (never hits), 1 = equal, 2 = greater, 3 = less. Compare and mask words use the byte layout of R2, and a mask bit set means that bit is not compared.
- R7: Greater and less compare the masked DA and the masked compare value as unsigned 48-bit numbers, with DA byte 0 most significant.
- R8: With compare length L in the length word, only DA bytes 0..L-1 take part in slot compares. A value of 0 or above 6 means 6.
- R9: For classifier n, OR-hit is any bit set in both the vector and the OR mask. AND-hit requires a non-zero AND mask whose bits are all set in the vector. Mode 0 gives OR-hit, 1 gives AND-hit, 2 gives both together and 3 gives either one.
- R10: The lowest-numbered classifier that hits and has its gate raw bit set wins, giving `out_accept`=1 and `out_class`=n. With no such classifier the pulse carries `out_accept`=0 and `out_class`=0.
- R11: The gate allow and phase bits have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Always 1, no back-pressure |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_meta | input | 4 | Side flags sampled on the start beat |
| out_valid | output | 1 | One-cycle decision pulse |
| out_accept | output | 1 | Frame accepted |
| out_class | output | 4 | Winning classifier index |
| out_match | output | 32 | Match vector of the frame |

## Verification
The hardest situation to reach from the ports is a frame on which several classifiers hit at once, with a lower-numbered one held back only by a clear raw bit while its allow and phase bits are set. This checks priority and gate handling together. Random configurations use sparse AND/OR masks drawn from the upper vector half, and random gates. Destination addresses are drawn to be the own MAC, broadcast, or a copy of a slot's compare value, so that overlapping hits are frequent. Directed frames add greater/less ordering at byte boundaries, short compare lengths, short frames and trailing bytes.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int DA_BYTES = 6;
  localparam int DA_BITS  = 8 * DA_BYTES;
  localparam int VEC_W    = 32;
  localparam int VB_SLOT0 = 16;

  typedef enum logic [1:0] {CMP_OFF, CMP_EQ, CMP_GT, CMP_LT} cmp_kind_e;
  typedef enum logic [1:0] {CMB_ANY, CMB_ALL, CMB_BOTH, CMB_EITHER} cmb_mode_e;

  // register word layout (byte 0 in [7:0]) to a number with byte 0 on top
  function automatic logic [DA_BITS-1:0] to_num(input logic [31:0] lo, input logic [15:0] hi);
    return {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
  endfunction
endpackage

// File: rtl/rxc_regs.sv
module rxc_regs import rxc_pkg::*; #(
  parameter int NSLOT = 8,
  parameter int NCLS  = 16,
  parameter int AW    = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  output logic [31:0]                mac_lo,
  output logic [15:0]                mac_hi,
  output logic [3:0]                 len_code,
  output logic [2*NSLOT-1:0]         slot_kind,
  output logic [2*NCLS-1:0]          cls_mode,
  output logic [NSLOT-1:0][31:0]     cmp_lo,
  output logic [NSLOT-1:0][15:0]     cmp_hi,
  output logic [NSLOT-1:0][31:0]     msk_lo,
  output logic [NSLOT-1:0][15:0]     msk_hi,
  output logic [NCLS-1:0][31:0]      and_en,
  output logic [NCLS-1:0][31:0]      or_en,
  output logic [NCLS-1:0]            gate_raw
);
  localparam int A_MAC_LO  = 0;
  localparam int A_MAC_HI  = 1;
  localparam int A_LEN     = 2;
  localparam int A_KIND    = 3;
  localparam int A_MODE    = 4;
  localparam int SLOT_BASE = 8;
  localparam int CLS_BASE  = SLOT_BASE + 4 * NSLOT;
  localparam int GATE_BASE = CLS_BASE + 2 * NCLS;

  logic [NCLS-1:0][2:0] gate_q;  // {allow, raw, phase}

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_lo    <= '0;
      mac_hi    <= '0;
      len_code  <= 4'(DA_BYTES);
      slot_kind <= '0;
      cls_mode  <= '0;
      cmp_lo    <= '0;
      cmp_hi    <= '0;
      msk_lo    <= '0;
      msk_hi    <= '0;
      and_en    <= '0;
      or_en     <= '0;
      gate_q    <= '0;
    end else if (we) begin
      if (addr == AW'(A_MAC_LO)) mac_lo    <= wdata;
      if (addr == AW'(A_MAC_HI)) mac_hi    <= wdata[15:0];
      if (addr == AW'(A_LEN))    len_code  <= wdata[19:16];
      if (addr == AW'(A_KIND))   slot_kind <= wdata[2*NSLOT-1:0];
      if (addr == AW'(A_MODE))   cls_mode  <= wdata[2*NCLS-1:0];
      for (int s = 0; s < NSLOT; s++) begin
        if (addr == AW'(SLOT_BASE + 4*s))     cmp_lo[s] <= wdata;
        if (addr == AW'(SLOT_BASE + 4*s + 1)) cmp_hi[s] <= wdata[15:0];
        if (addr == AW'(SLOT_BASE + 4*s + 2)) msk_lo[s] <= wdata;
        if (addr == AW'(SLOT_BASE + 4*s + 3)) msk_hi[s] <= wdata[15:0];
      end
      for (int c = 0; c < NCLS; c++) begin
        if (addr == AW'(CLS_BASE + 2*c))     and_en[c] <= wdata;
        if (addr == AW'(CLS_BASE + 2*c + 1)) or_en[c]  <= wdata;
        if (addr == AW'(GATE_BASE + c))      gate_q[c] <= wdata[6:4];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(A_MAC_LO)) rdata = mac_lo;
    if (addr == AW'(A_MAC_HI)) rdata = {16'd0, mac_hi};
    if (addr == AW'(A_LEN))    rdata = {12'd0, len_code, 16'd0};
    if (addr == AW'(A_KIND))   rdata = 32'(slot_kind);
    if (addr == AW'(A_MODE))   rdata = 32'(cls_mode);
    for (int s = 0; s < NSLOT; s++) begin
      if (addr == AW'(SLOT_BASE + 4*s))     rdata = cmp_lo[s];
      if (addr == AW'(SLOT_BASE + 4*s + 1)) rdata = {16'd0, cmp_hi[s]};
      if (addr == AW'(SLOT_BASE + 4*s + 2)) rdata = msk_lo[s];
      if (addr == AW'(SLOT_BASE + 4*s + 3)) rdata = {16'd0, msk_hi[s]};
    end
    for (int c = 0; c < NCLS; c++) begin
      if (addr == AW'(CLS_BASE + 2*c))     rdata = and_en[c];
      if (addr == AW'(CLS_BASE + 2*c + 1)) rdata = or_en[c];
      if (addr == AW'(GATE_BASE + c))      rdata = {25'd0, gate_q[c], 4'd0};
    end
  end

  always_comb
    for (int c = 0; c < NCLS; c++) gate_raw[c] = gate_q[c][1];

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(len_code) && $stable(cls_mode) && $stable(slot_kind)); // R2
endmodule

// File: rtl/rxc_slot.sv
module rxc_slot import rxc_pkg::*; (
  input  logic [DA_BITS-1:0] da_num,
  input  logic [DA_BITS-1:0] care_len,
  input  logic [31:0]        cmp_lo,
  input  logic [15:0]        cmp_hi,
  input  logic [31:0]        msk_lo,
  input  logic [15:0]        msk_hi,
  input  cmp_kind_e          kind,
  output logic               hit
);
  logic [DA_BITS-1:0] care, d_m, c_m;

  always_comb begin
    care = ~to_num(msk_lo, msk_hi) & care_len;
    d_m  = da_num & care;
    c_m  = to_num(cmp_lo, cmp_hi) & care;
    unique case (kind)
      CMP_EQ:  hit = (d_m == c_m);
      CMP_GT:  hit = (d_m > c_m);
      CMP_LT:  hit = (d_m < c_m);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxc_class.sv
module rxc_class import rxc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] vec,
  input  logic [VEC_W-1:0] and_en,
  input  logic [VEC_W-1:0] or_en,
  input  cmb_mode_e        mode,
  output logic             hit
);
  logic any_hit, all_hit;

  always_comb begin
    any_hit = |(vec & or_en);
    all_hit = (and_en != '0) && ((vec & and_en) == and_en);
    unique case (mode)
      CMB_ANY:  hit = any_hit;
      CMB_ALL:  hit = all_hit;
      CMB_BOTH: hit = any_hit && all_hit;
      default:  hit = any_hit || all_hit;
    endcase
  end

  AST_EMPTY_AND_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CMB_ALL && and_en == '0) |-> !hit); // R9
  AST_EMPTY_OR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CMB_ANY && or_en == '0) |-> !hit); // R9
endmodule

// File: rtl/eth_rx_classifier.sv
module eth_rx_classifier import rxc_pkg::*; #(
  parameter int NSLOT = 8,
  parameter int NCLS  = 16,
  localparam int CFG_AW = $clog2(8 + 4*NSLOT + 3*NCLS),
  localparam int CLS_W  = $clog2(NCLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [3:0]        in_meta,
  output logic              out_valid,
  output logic              out_accept,
  output logic [CLS_W-1:0]  out_class,
  output logic [VEC_W-1:0]  out_match
);
  localparam int CW = $clog2(DA_BYTES + 1);

  logic [31:0]                mac_lo;
  logic [15:0]                mac_hi;
  logic [3:0]                 len_code, len_eff;
  logic [2*NSLOT-1:0]         slot_kind;
  logic [2*NCLS-1:0]          cls_mode;
  logic [NSLOT-1:0][31:0]     cmp_lo, msk_lo;
  logic [NSLOT-1:0][15:0]     cmp_hi, msk_hi;
  logic [NCLS-1:0][31:0]      and_en, or_en;
  logic [NCLS-1:0]            gate_raw, cls_hit;
  logic [NSLOT-1:0]           slot_hit;

  logic [DA_BYTES-1:0][7:0]   da_q;
  logic [CW-1:0]              cnt;
  logic [3:0]                 meta_q;
  logic                       eval_q;
  logic [DA_BITS-1:0]         da_num, care_len;
  logic [VEC_W-1:0]           vec;
  logic                       win;
  logic [CLS_W-1:0]           win_idx;

  rxc_regs #(.NSLOT(NSLOT), .NCLS(NCLS), .AW(CFG_AW)) u_regs (
    .clk, .rst_n, .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .mac_lo, .mac_hi, .len_code, .slot_kind, .cls_mode,
    .cmp_lo, .cmp_hi, .msk_lo, .msk_hi, .and_en, .or_en, .gate_raw
  );

  assign in_ready = 1'b1;

  // destination address capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      da_q   <= '0;
      cnt    <= '0;
      meta_q <= '0;
      eval_q <= 1'b0;
    end else begin
      eval_q <= 1'b0;
      if (in_valid) begin
        if (in_sof) begin
          da_q[0] <= in_data;
          meta_q  <= in_meta;
          cnt     <= CW'(1);
        end else if (cnt != '0 && cnt < CW'(DA_BYTES)) begin
          da_q[cnt] <= in_data;
          cnt       <= cnt + CW'(1);
          if (cnt == CW'(DA_BYTES - 1)) eval_q <= 1'b1;
        end
        if (in_eof) cnt <= '0;
      end
    end
  end

  always_comb begin
    len_eff = (len_code == 4'd0 || len_code > 4'(DA_BYTES)) ? 4'(DA_BYTES) : len_code;
    for (int i = 0; i < DA_BYTES; i++) begin
      da_num[DA_BITS-1-8*i -: 8]   = da_q[i];
      care_len[DA_BITS-1-8*i -: 8] = (4'(i) < len_eff) ? 8'hFF : 8'h00;
    end
  end

  always_comb begin
    vec     = '0;
    vec[31] = ~da_q[0][0];
    vec[30] = da_q[0][0];
    vec[29] = &da_num;
    vec[28] = meta_q[3];
    vec[27] = meta_q[2];
    vec[26] = meta_q[1];
    vec[25] = (da_num == to_num(mac_lo, mac_hi));
    vec[24] = meta_q[0];
    vec[VB_SLOT0 +: NSLOT] = slot_hit;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    rxc_slot u_slot (
      .da_num, .care_len,
      .cmp_lo(cmp_lo[s]), .cmp_hi(cmp_hi[s]), .msk_lo(msk_lo[s]), .msk_hi(msk_hi[s]),
      .kind(cmp_kind_e'(slot_kind[2*s +: 2])), .hit(slot_hit[s])
    );
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    rxc_class u_cls (
      .clk, .rst_n, .vec, .and_en(and_en[c]), .or_en(or_en[c]),
      .mode(cmb_mode_e'(cls_mode[2*c +: 2])), .hit(cls_hit[c])
    );
  end

  // lowest index with a raw gate wins
  always_comb begin
    win     = 1'b0;
    win_idx = '0;
    for (int c = NCLS - 1; c >= 0; c--) begin
      if (cls_hit[c] && gate_raw[c]) begin
        win     = 1'b1;
        win_idx = CLS_W'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
      out_class  <= '0;
      out_match  <= '0;
    end else begin
      out_valid  <= eval_q;
      out_accept <= eval_q && win;
      out_class  <= (eval_q && win) ? win_idx : '0;
      out_match  <= eval_q ? vec : '0;
    end
  end

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R3
  AST_UC_MC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_match[31] != out_match[30])); // R4
  AST_BC_IS_MC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_match[29]) |-> out_match[30]); // R4
  AST_LOW_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_match[15:0] == 16'd0)); // R4
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_accept && out_class == '0)); // R10
endmodule

// File: tb/eth_rx_classifier_test.sv
module eth_rx_classifier_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        in_valid = 1'b0, in_ready, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic [3:0]  in_meta = '0;
  logic        out_valid, out_accept;
  logic [3:0]  out_class;
  logic [31:0] out_match;

  always #10 clk = ~clk;

  eth_rx_classifier uut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .in_valid, .in_ready, .in_data, .in_sof, .in_eof, .in_meta,
    .out_valid, .out_accept, .out_class, .out_match
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] sh_mac_lo, sh_mac_hi, sh_len, sh_kind, sh_mode;
  logic [31:0] sh_clo[8], sh_chi[8], sh_mlo[8], sh_mhi[8];
  logic [31:0] sh_and[16], sh_or[16], sh_gate[16];
  logic [7:0]  fda[6];
  logic [3:0]  fmeta;
  logic        got_acc;
  logic [3:0]  got_cls;
  logic [31:0] got_vec;

  function automatic int a_slot(int n, int k); return 8 + 4*n + k; endfunction
  function automatic int a_and(int n);  return 40 + 2*n; endfunction
  function automatic int a_or(int n);   return 41 + 2*n; endfunction
  function automatic int a_gate(int n); return 72 + n; endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 0) sh_mac_lo = d;
    if (a == 1) sh_mac_hi = d & 32'hFFFF;
    if (a == 2) sh_len = d & 32'h000F_0000;
    if (a == 3) sh_kind = d & 32'hFFFF;
    if (a == 4) sh_mode = d;
    for (int s = 0; s < 8; s++) begin
      if (a == a_slot(s,0)) sh_clo[s] = d;
      if (a == a_slot(s,1)) sh_chi[s] = d & 32'hFFFF;
      if (a == a_slot(s,2)) sh_mlo[s] = d;
      if (a == a_slot(s,3)) sh_mhi[s] = d & 32'hFFFF;
    end
    for (int c = 0; c < 16; c++) begin
      if (a == a_and(c))  sh_and[c]  = d;
      if (a == a_or(c))   sh_or[c]   = d;
      if (a == a_gate(c)) sh_gate[c] = d & 32'h70;
    end
  endtask

  task automatic rd_chk(string req, int a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = 7'(a);
    #1 check(req, cfg_rdata, exp);
  endtask

  function automatic logic [7:0] wbyte(logic [31:0] lo, logic [31:0] hi, int i);
    return (i < 4) ? lo[8*i +: 8] : hi[8*(i-4) +: 8];
  endfunction

  function automatic int eff_len();
    int l = int'(sh_len[19:16]);
    return (l == 0 || l > 6) ? 6 : l;
  endfunction

  function automatic bit slot_hit(int n);
    int kind = int'(sh_kind[2*n +: 2]);
    int rel = 0;
    if (kind == 0) return 1'b0;
    for (int i = 0; i < eff_len(); i++) begin
      logic [7:0] mb = wbyte(sh_mlo[n], sh_mhi[n], i);
      logic [7:0] d = fda[i] & ~mb;
      logic [7:0] c = wbyte(sh_clo[n], sh_chi[n], i) & ~mb;
      if (rel == 0 && d != c) rel = (d > c) ? 1 : -1;
    end
    return (kind == 1) ? (rel == 0) : (kind == 2) ? (rel == 1) : (rel == -1);
  endfunction

  function automatic logic [31:0] exp_vec();
    logic [31:0] v = '0;
    bit own = 1'b1, bc = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (fda[i] != wbyte(sh_mac_lo, sh_mac_hi, i)) own = 1'b0;
      if (fda[i] != 8'hFF) bc = 1'b0;
    end
    v[31] = !fda[0][0]; v[30] = fda[0][0]; v[29] = bc;
    v[28] = fmeta[3]; v[27] = fmeta[2]; v[26] = fmeta[1]; v[24] = fmeta[0];
    v[25] = own;
    for (int s = 0; s < 8; s++) v[16+s] = slot_hit(s);
    return v;
  endfunction

  function automatic bit cls_hit(int n, logic [31:0] v);
    bit o = |(v & sh_or[n]);
    bit a = (sh_and[n] != 0) && ((v & sh_and[n]) == sh_and[n]);
    case (sh_mode[2*n +: 2])
      2'd0: return o;
      2'd1: return a;
      2'd2: return o && a;
      default: return o || a;
    endcase
  endfunction

  // sends fda/fmeta; ntrail extra bytes; short=1 ends the frame after 4 bytes
  task automatic run_frame(int ntrail, bit short_f);
    logic [31:0] ev = exp_vec();
    bit ea = 1'b0;
    logic [3:0] ec = '0;
    int total = short_f ? 4 : 6 + ntrail;
    for (int c = 15; c >= 0; c--)
      if (cls_hit(c, ev) && sh_gate[c][5]) begin ea = 1'b1; ec = 4'(c); end
    for (int k = 0; k < total + 3; k++) begin
      @(negedge clk);
      if (short_f) begin
        check("R3 no pulse for short frame", 32'(out_valid), 0);
      end else if (k == 7) begin
        got_acc = out_accept; got_cls = out_class; got_vec = out_match;
        check("R3 valid pulse", 32'(out_valid), 1);
        check("R4 match vector", out_match, ev);
        check("R10 accept", 32'(out_accept), 32'(ea));
        check("R10 class", 32'(out_class), 32'(ec));
      end else if (k == 6 || k == 8) begin
        check("R3 pulse width", 32'(out_valid), 0);
      end
      check("R3 ready high", 32'(in_ready), 1);
      if (k < total) begin
        in_valid = 1'b1;
        in_sof   = (k == 0);
        in_eof   = (k == total - 1);
        in_data  = (k < 6) ? fda[k] : 8'($urandom);
        in_meta  = (k == 0) ? fmeta : 4'($urandom);
      end else begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        in_data = 8'($urandom); in_meta = 4'($urandom);
      end
    end
  endtask

  task automatic set_da(logic [47:0] v);  // v[47:40] is byte 0
    for (int i = 0; i < 6; i++) fda[i] = v[47-8*i -: 8];
  endtask

  task automatic clear_cfg();
    wr(0, 0); wr(1, 0); wr(2, 32'h0006_0000); wr(3, 0); wr(4, 0);
    for (int s = 0; s < 8; s++) for (int k = 0; k < 4; k++) wr(a_slot(s,k), 0);
    for (int c = 0; c < 16; c++) begin wr(a_and(c), 0); wr(a_or(c), 0); wr(a_gate(c), 0); end
  endtask

  function automatic logic [31:0] pick_bits();
    logic [31:0] m = '0;
    int r = int'($urandom % 4);
    for (int i = 0; i < r; i++) m |= 32'd1 << (16 + ($urandom % 16));
    return m;
  endfunction

  task automatic rand_config();
    wr(0, $urandom); wr(1, $urandom);
    wr(2, ($urandom % 4 == 0) ? ($urandom & 32'h000F_0000) : 32'h0006_0000);
    wr(3, $urandom); wr(4, $urandom);
    for (int s = 0; s < 8; s++) begin
      wr(a_slot(s,0), $urandom); wr(a_slot(s,1), $urandom);
      wr(a_slot(s,2), ($urandom % 2) ? ($urandom & $urandom & $urandom) : 0);
      wr(a_slot(s,3), ($urandom % 2) ? ($urandom & $urandom) : 0);
    end
    for (int c = 0; c < 16; c++) begin
      wr(a_and(c), pick_bits()); wr(a_or(c), pick_bits()); wr(a_gate(c), $urandom);
    end
  endtask

  task automatic rand_da();
    int sel = int'($urandom % 5);
    int s = int'($urandom % 8);
    for (int i = 0; i < 6; i++) begin
      case (sel)
        1: fda[i] = wbyte(sh_mac_lo, sh_mac_hi, i);
        2: fda[i] = 8'hFF;
        3: fda[i] = wbyte(sh_clo[s], sh_chi[s], i) ^ ((i == 5 && $urandom % 2) ? 8'h01 : 8'h00);
        default: fda[i] = 8'($urandom);
      endcase
    end
    if (sel == 4) fda[0][0] = 1'b0;
    fmeta = 4'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    sh_mac_lo = 0; sh_mac_hi = 0; sh_len = 32'h0006_0000; sh_kind = 0; sh_mode = 0;
    for (int s = 0; s < 8; s++) begin sh_clo[s] = 0; sh_chi[s] = 0; sh_mlo[s] = 0; sh_mhi[s] = 0; end
    for (int c = 0; c < 16; c++) begin sh_and[c] = 0; sh_or[c] = 0; sh_gate[c] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 out_accept", 32'(out_accept), 0);
    check("R1 out_match", out_match, 0);
    rst_n = 1'b1;
    rd_chk("R1 length word", 2, 32'h0006_0000);
    rd_chk("R1 mac low", 0, 0);
    rd_chk("R1 gate", a_gate(9), 0);
    rd_chk("R1 or mask", a_or(15), 0);

    // R2 stored bits and read-back
    wr(a_gate(3), 32'hFFFF_FFFF); rd_chk("R2 gate bits", a_gate(3), 32'h70);
    wr(a_slot(7,3), 32'hFFFF_FFFF); rd_chk("R2 mask high", a_slot(7,3), 32'hFFFF);
    wr(2, 32'hFFFF_FFFF); rd_chk("R2 length bits", 2, 32'h000F_0000);
    wr(a_and(5), 32'hA5A5_1234); rd_chk("R2 and mask", a_and(5), 32'hA5A5_1234);
    wr(127, 32'hFFFF_FFFF); rd_chk("R2 unmapped", 127, 0);
    rd_chk("R2 unmapped write left and mask", a_and(5), 32'hA5A5_1234);
    clear_cfg();

    // R5/R10 broadcast or own address through classifier 4, mode either
    wr(0, 32'h4433_2211); wr(1, 32'h0000_6655);
    wr(a_or(4), 32'h2200_0000); wr(4, 32'd3 << 8); wr(a_gate(4), 32'h20);
    fmeta = 4'h0;
    set_da(48'h11_22_33_44_55_66); run_frame(0, 0);
    check("R5 own address bit", 32'(got_vec[25]), 1);
    check("R10 own address class 4", 32'(got_cls), 4);
    set_da(48'hFF_FF_FF_FF_FF_FF); run_frame(2, 0);
    check("R4 broadcast bit", 32'(got_vec[29]), 1);
    check("R3 trailing bytes ignored", 32'(got_acc), 1);
    set_da(48'h11_22_33_44_55_67); run_frame(0, 0);
    check("R5 last byte differs", 32'(got_vec[25]), 0);
    check("R10 no winner", 32'(got_acc), 0);

    // R6 slot 0 equal with mask FE-FF-FF-FF-FF-FF catches every unicast
    wr(3, 32'h1); wr(a_slot(0,2), 32'hFFFF_FFFE); wr(a_slot(0,3), 32'hFFFF);
    wr(a_or(4), 32'h6001_0000);
    set_da(48'h02_9A_00_13_77_01); fmeta = 4'hA; run_frame(0, 0);
    check("R6 unicast slot 0 hit", 32'(got_vec[16]), 1);
    check("R4 meta flags", {28'd0, got_vec[28], got_vec[27], got_vec[26], got_vec[24]}, 32'hA);

    // R11 allow and phase without raw do not forward; raw alone does
    wr(a_or(2), 32'h0001_0000); wr(a_gate(2), 32'h50);
    run_frame(0, 0);
    check("R11 class 2 gated", 32'(got_cls), 4);
    wr(a_gate(2), 32'h20); run_frame(0, 0);
    check("R11 raw alone forwards", 32'(got_cls), 2);
    check("R10 lower index wins", 32'(got_acc), 1);

    // R7 greater/less with byte 0 most significant
    clear_cfg();
    wr(a_slot(1,0), 32'h0000_0010); wr(a_slot(2,0), 32'h0000_0010);
    wr(3, (32'd2 << 2) | (32'd3 << 4));
    fmeta = 4'h0;
    set_da(48'h10_00_00_00_00_01); run_frame(0, 0);
    check("R7 greater by last byte", 32'(got_vec[17]), 1);
    check("R7 not less", 32'(got_vec[18]), 0);
    set_da(48'h0F_FF_FF_FF_FF_FF); run_frame(0, 0);
    check("R7 less by first byte", 32'(got_vec[18]), 1);
    check("R7 not greater", 32'(got_vec[17]), 0);

    // R8 compare length: only two bytes compared
    wr(a_slot(3,0), 32'h0000_BBAA); wr(3, 32'd1 << 6);
    set_da(48'hAA_BB_01_02_03_04); run_frame(0, 0);
    check("R8 six bytes miss", 32'(got_vec[19]), 0);
    wr(2, 32'h0002_0000); run_frame(0, 0);
    check("R8 two bytes hit", 32'(got_vec[19]), 1);
    wr(2, 32'h0000_0000); run_frame(0, 0);
    check("R8 zero means six", 32'(got_vec[19]), 0);

    // R9 empty and mask never hits; both-mode needs both halves
    wr(a_gate(0), 32'h20); wr(4, 32'h1); wr(a_and(0), 0);
    set_da(48'hFF_FF_FF_FF_FF_FF); run_frame(0, 0);
    check("R9 empty and mask", 32'(got_acc), 0);
    wr(4, 32'h2); wr(a_and(0), 32'h2000_0000); wr(a_or(0), 32'h0100_0000);
    run_frame(0, 0);
    check("R9 both needs or half", 32'(got_acc), 0);
    fmeta = 4'h1; run_frame(0, 0);
    check("R9 both satisfied", 32'(got_acc), 1);

    // R3 short frame, then stray bytes with no frame open
    run_frame(0, 1);
    @(negedge clk); in_valid = 1'b1; in_data = 8'h55;
    repeat (8) @(negedge clk);
    in_valid = 1'b0;
    check("R3 stray bytes no pulse", 32'(out_valid), 0);

    // random configurations and addresses
    for (int r = 0; r < 30; r++) begin
      rand_config();
      for (int f = 0; f < 12; f++) begin
        rand_da();
        run_frame(int'($urandom % 3), 1'b0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule